// File: doc/BRIEF.md
# Nine-Level Reversing-Bridge PWM Modulator

This block produces the twelve switch commands for a single-phase nine-level inverter that is split into two parts. One part builds a positive stepped voltage from zero to four steps and switches at carrier rate. The other part is a bridge that flips the polarity of that stepped voltage and only changes state when the reference changes sign. The modulator takes a signed reference sample, works out its magnitude, and compares it against four carriers that all sit above zero. The number of carriers the magnitude exceeds is the output level. The sign of the reference sets the polarity bridge.

Reference samples arrive on a valid/ready stream. The block captures a sample on every clock edge where both valid and ready are high. It holds that sample until the next one is accepted, so the source may send samples at any rate up to one per clock. Ready is low during reset and high at all other times. The block never applies back-pressure once it is running. The carrier shape (mode) and the carrier half-period are plain control pins that are read continuously.

Top module: `rvm_modulator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sw_level` is 8'h1E and `sw_pol` is 4'h5, `ref_ready` is 0, and the carrier phase counter is 0.
- R2: `ref_ready` is 1 whenever reset is released. A sample is captured on an edge where `ref_valid` and `ref_ready` are both 1, and the outputs reflect it from the following edge. While `ref_valid` is 0, changes on `ref_data` have no effect.
- R3: The phase counter goes up by one each cycle from 0 to 2P-1 and then wraps to 0, where P is `car_period` (a value of 0 is used as 1). The triangle value t equals the phase while the phase is at most P, and 2P minus the phase otherwise. Carrier k (k = 0..3) is k*P + t.
- R4: The level is the count of carriers strictly below the magnitude |ref|. The magnitude saturates, so the most negative code has magnitude 2^(W-1)-1. A zero reference always gives level 0.
- R5: The `car_mode` encoding is: 2'b00 in-phase carriers, 2'b01 opposed-about-zero, which equals 2'b00 because every carrier is positive, 2'b10 alternate carriers inverted (odd k uses k*P + P - t), and 2'b11 behaves as 2'b00.
- R6: `sw_level` bit i drives level switch i+1. The patterns are 8'h1E for level 0, 8'h2E for level 1, 8'hA6 for level 2, 8'h62 for level 3 and 8'h21 for level 4, and they are the same for either sign.
- R7: `sw_pol` bit i drives bridge switch i+1. For a nonzero level it is 4'h9 when the reference is non-negative (sign bit 0) and 4'h6 when it is negative. No other pattern besides 4'h5 ever appears.
- R8: When the level is 0, `sw_pol` is 4'h5 whatever the sign, and 4'h5 appears only with level 0.
- R9: The most negative reference code gives level 4 (8'h21) with `sw_pol` 4'h6 whenever 4P is below 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Block can take a sample (high out of reset) |
| ref_data | input | REF_W | Signed reference sample |
| car_mode | input | 2 | Carrier arrangement select |
| car_period | input | PER_W | Carrier half-period P in clocks, also the carrier height |
| sw_level | output | 8 | Level-stage switch commands, registered |
| sw_pol | output | 4 | Polarity-bridge switch commands, registered |

## Verification
The bench goes after four corner cases. The first is a reference exactly at full scale 4P, which should drop to level 3 at the triangle peak because the comparison is strict; a design using greater-or-equal would stay at level 4. The second is the most negative code, where a plain negation wraps to a tiny or negative magnitude and gives level 0 instead of 4. The third is a small negative reference that falls to level 0 for part of the carrier cycle; there the bridge must show the zero pattern and not the negative one. The fourth is the inverted-carrier mode, which a design ignoring the mode would treat as in-phase, and the bench also drives garbage on the data port while valid is low to catch capture without a handshake.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

  localparam int NUM_CAR = 4;
  localparam int LVL_W   = 3;
  localparam int NSW_LVL = 8;
  localparam int NSW_POL = 4;

  typedef enum logic [1:0] {
    CM_INPHASE  = 2'b00,
    CM_OPPOSED  = 2'b01,
    CM_ALTERNATE = 2'b10,
    CM_SPARE    = 2'b11
  } car_mode_e;

  localparam logic [NSW_POL-1:0] POL_POS  = 4'h9;
  localparam logic [NSW_POL-1:0] POL_NEG  = 4'h6;
  localparam logic [NSW_POL-1:0] POL_ZERO = 4'h5;

  localparam logic [NSW_LVL-1:0] LVL_PAT0 = 8'h1E;
  localparam logic [NSW_LVL-1:0] LVL_PAT1 = 8'h2E;
  localparam logic [NSW_LVL-1:0] LVL_PAT2 = 8'hA6;
  localparam logic [NSW_LVL-1:0] LVL_PAT3 = 8'h62;
  localparam logic [NSW_LVL-1:0] LVL_PAT4 = 8'h21;

  function automatic logic [NSW_LVL-1:0] level_pattern(input logic [LVL_W-1:0] lvl);
    logic [NSW_LVL-1:0] p;
    case (lvl)
      3'd0:    p = LVL_PAT0;
      3'd1:    p = LVL_PAT1;
      3'd2:    p = LVL_PAT2;
      3'd3:    p = LVL_PAT3;
      default: p = LVL_PAT4;
    endcase
    return p;
  endfunction

  function automatic logic [NSW_POL-1:0] bridge_pattern(input logic is_zero,
                                                        input logic is_neg);
    logic [NSW_POL-1:0] p;
    if (is_zero)     p = POL_ZERO;
    else if (is_neg) p = POL_NEG;
    else             p = POL_POS;
    return p;
  endfunction

endpackage

// File: rtl/rvm_carrier.sv
module rvm_carrier #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] per_eff_o,
  output logic [PER_W-1:0] tri_o
);
  localparam int PH_W = PER_W + 1;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] wrap_at;
  logic [PH_W-1:0] per_ext;

  assign per_eff_o = (period_i == '0) ? PER_W'(1) : period_i;
  assign per_ext   = PH_W'(per_eff_o);
  assign wrap_at   = (per_ext << 1) - PH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ph_q <= '0;
    else if (ph_q >= wrap_at) ph_q <= '0;
    else                    ph_q <= ph_q + PH_W'(1);
  end

  always_comb begin
    if (ph_q <= per_ext) tri_o = PER_W'(ph_q);
    else                 tri_o = PER_W'((per_ext << 1) - ph_q);
  end

  AST_TRI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tri_o <= per_eff_o);  // R3
  AST_PH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == wrap_at) |=> (ph_q == '0));  // R3

endmodule

// File: rtl/rvm_level_quant.sv
module rvm_level_quant
  import rvm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int PER_W = 8
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [1:0]              mode_i,
  input  logic [PER_W-1:0]        per_i,
  input  logic [PER_W-1:0]        tri_i,
  output logic [LVL_W-1:0]        lvl_o,
  output logic                    neg_o
);
  localparam int MAG_W = REF_W - 1;
  localparam int CMP_W = (MAG_W > PER_W + 3) ? MAG_W : PER_W + 3;
  localparam logic [REF_W-1:0] MOST_NEG = {1'b1, {(REF_W-1){1'b0}}};

  logic [MAG_W-1:0] mag;
  logic [CMP_W-1:0] mag_ext;
  logic [REF_W-1:0] negated;
  logic             invert_odd;
  logic [NUM_CAR-1:0] above;

  assign negated = -ref_i;
  assign neg_o   = ref_i[REF_W-1];

  always_comb begin
    if (!ref_i[REF_W-1])                    mag = MAG_W'(ref_i);
    else if (REF_W'(ref_i) == MOST_NEG)     mag = '1;
    else                                    mag = negated[MAG_W-1:0];
  end

  assign mag_ext    = CMP_W'(mag);
  assign invert_odd = (car_mode_e'(mode_i) == CM_ALTERNATE);

  for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] offs;
    logic [CMP_W-1:0] carrier;
    assign base = CMP_W'(k) * CMP_W'(per_i);
    if (k % 2 == 1) begin : g_odd
      assign offs = invert_odd ? CMP_W'(per_i - tri_i) : CMP_W'(tri_i);
    end else begin : g_even
      assign offs = CMP_W'(tri_i);
    end
    assign carrier  = base + offs;
    assign above[k] = (mag_ext > carrier);
  end

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NUM_CAR; i++) begin
      lvl_o = lvl_o + LVL_W'(above[i]);
    end
  end

endmodule

// File: rtl/rvm_switch_map.sv
module rvm_switch_map
  import rvm_pkg::*;
(
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               neg_i,
  output logic [NSW_LVL-1:0] lvl_pat_o,
  output logic [NSW_POL-1:0] pol_pat_o
);
  assign lvl_pat_o = level_pattern(lvl_i);
  assign pol_pat_o = bridge_pattern(lvl_i == '0, neg_i);
endmodule

// File: rtl/rvm_modulator.sv
module rvm_modulator
  import rvm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int PER_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_data,
  input  logic [1:0]              car_mode,
  input  logic [PER_W-1:0]        car_period,
  output logic [NSW_LVL-1:0]      sw_level,
  output logic [NSW_POL-1:0]      sw_pol
);
  localparam logic [REF_W-1:0] MOST_NEG = {1'b1, {(REF_W-1){1'b0}}};
  localparam int MAX_MAG = (1 << (REF_W - 1)) - 1;

  logic signed [REF_W-1:0] ref_q;
  logic                    ready_q;
  logic [PER_W-1:0]        per_eff;
  logic [PER_W-1:0]        tri_val;
  logic [LVL_W-1:0]        lvl;
  logic                    neg;
  logic [NSW_LVL-1:0]      lvl_pat;
  logic [NSW_POL-1:0]      pol_pat;

  assign ref_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (ref_valid && ready_q) ref_q <= ref_data;
    end
  end

  rvm_carrier #(.PER_W(PER_W)) u_car (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (car_period),
    .per_eff_o(per_eff),
    .tri_o    (tri_val)
  );

  rvm_level_quant #(.REF_W(REF_W), .PER_W(PER_W)) u_quant (
    .ref_i (ref_q),
    .mode_i(car_mode),
    .per_i (per_eff),
    .tri_i (tri_val),
    .lvl_o (lvl),
    .neg_o (neg)
  );

  rvm_switch_map u_map (
    .lvl_i    (lvl),
    .neg_i    (neg),
    .lvl_pat_o(lvl_pat),
    .pol_pat_o(pol_pat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_level <= LVL_PAT0;
      sw_pol   <= POL_ZERO;
    end else begin
      sw_level <= lvl_pat;
      sw_pol   <= pol_pat;
    end
  end

  AST_POL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pol == POL_POS) || (sw_pol == POL_NEG) || (sw_pol == POL_ZERO));  // R7
  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_level == LVL_PAT0) |-> (sw_pol == POL_ZERO));  // R8
  AST_ZERO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pol == POL_ZERO) |-> (sw_level == LVL_PAT0));  // R8
  AST_ZERO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q == '0) |=> (sw_level == LVL_PAT0));  // R4
  AST_SAT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((REF_W'(ref_q) == MOST_NEG) && (4 * int'(per_eff) < MAX_MAG))
      |=> ((sw_level == LVL_PAT4) && (sw_pol == POL_NEG)));  // R9
  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ref_ready);  // R2

endmodule

// File: tb/tb_rvm_modulator.sv
`timescale 1ns/1ps
module tb_rvm_modulator;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_valid = 1'b0;
  logic              ref_ready;
  logic signed [11:0] ref_data = '0;
  logic [1:0]        car_mode = 2'b00;
  logic [7:0]        car_period = 8'd20;
  logic [7:0]        sw_level;
  logic [3:0]        sw_pol;

  int n_tests = 0;
  int n_fail  = 0;
  int p_tb    = 20;
  int ph_m    = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rvm_modulator dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_valid (ref_valid),
    .ref_ready (ref_ready),
    .ref_data  (ref_data),
    .car_mode  (car_mode),
    .car_period(car_period),
    .sw_level  (sw_level),
    .sw_pol    (sw_pol)
  );

  // R3 phase model: 0..2P-1 then wrap
  always @(posedge clk) begin
    if (!rst_n) ph_m <= 0;
    else if (ph_m >= 2 * p_tb - 1) ph_m <= 0;
    else ph_m <= ph_m + 1;
  end

  function automatic logic [11:0] expect_sw(input logic signed [11:0] r,
                                            input logic [1:0] m,
                                            input int ph, input int p);
    int mag, t, car, lvl;
    logic [7:0] lp;
    logic [3:0] pp;
    if (r == -12'sd2048) mag = 2047;
    else if (r < 0) mag = -int'(r);
    else mag = int'(r);
    t = (ph <= p) ? ph : 2 * p - ph;
    lvl = 0;
    for (int k = 0; k < 4; k++) begin
      car = k * p + (((m == 2'b10) && (k % 2 == 1)) ? (p - t) : t);
      if (mag > car) lvl++;
    end
    case (lvl)
      0: lp = 8'h1E;
      1: lp = 8'h2E;
      2: lp = 8'hA6;
      3: lp = 8'h62;
      default: lp = 8'h21;
    endcase
    if (lvl == 0) pp = 4'h5;
    else if (r < 0) pp = 4'h6;
    else pp = 4'h9;
    return {pp, lp};
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got pol=%h lvl=%h expected pol=%h lvl=%h",
               tag, act[11:8], act[7:0], exp[11:8], exp[7:0]);
    end
  endtask

  // capture a sample, then hold it with junk on the data port (R2)
  task automatic run_vec(input logic signed [11:0] r, input logic [1:0] m,
                         input int ncyc, input string tag);
    logic [11:0] exp_prev;
    @(negedge clk);
    ref_data  = r;
    ref_valid = 1'b1;
    car_mode  = m;
    @(negedge clk);
    ref_valid = 1'b0;
    ref_data  = ~r;
    exp_prev  = expect_sw(r, m, ph_m, p_tb);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      check(tag, {sw_pol, sw_level}, exp_prev);
      ref_data = 12'(c * 37);
      exp_prev = expect_sw(r, m, ph_m, p_tb);
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst_n = 1'b0;
    ref_valid = 1'b0;
    p_tb = p;
    car_period = 8'(p);
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {sw_pol, sw_level}, 12'h51E);
    check("R1 ready low", {11'd0, ref_ready}, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle outputs", {sw_pol, sw_level}, 12'h51E);
    check("R2 ready high", {11'd0, ref_ready}, 12'h001);
  endtask

  // mode(2) , ref(12)
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 12'h000}, {2'b00, 12'h00A}, {2'b00, 12'h01E}, {2'b00, 12'h032},
    {2'b00, 12'h046}, {2'b00, 12'h05A}, {2'b00, 12'h050}, {2'b00, 12'hFF6},
    {2'b00, 12'hFE2}, {2'b01, 12'hFCE}, {2'b01, 12'h032}, {2'b10, 12'h01E},
    {2'b10, 12'hFBA}, {2'b10, 12'h046}, {2'b11, 12'h032}, {2'b00, 12'hFFF}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(20);
    // R3 R4 R5 R6 R7 R8 walked over the table, each for two carrier cycles
    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][11:0], VEC[i][13:12], 4 * p_tb + 2, "R2 R3 R4 R5 R6 R7 R8 table");
    end
    // R9 most negative code saturates
    run_vec(-12'sd2048, 2'b00, 2 * p_tb, "R9 most negative");
    run_vec(12'sd2047, 2'b10, 2 * p_tb, "R4 most positive");
    // R8 negative reference that falls to level 0 in part of the cycle
    run_vec(-12'sd5, 2'b00, 2 * p_tb, "R8 small negative");
    // R1 reset mid-run, then a different period
    do_reset(7);
    run_vec(12'sd15, 2'b10, 4 * p_tb, "R3 R5 short period alternate");
    run_vec(-12'sd27, 2'b01, 4 * p_tb, "R5 R7 short period opposed");
    run_vec(12'sd28, 2'b00, 4 * p_tb, "R4 full scale boundary");
    run_vec(-12'sd2048, 2'b10, 2 * p_tb, "R9 most negative alternate");
    run_vec(12'sd0, 2'b00, 2 * p_tb, "R4 R6 zero reference");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule